// File: doc/BRIEF.md
# Context-Tagged Translation Lookaside Buffer

This block is a small, fully associative translation cache. It maps 4 KiB linear page numbers to physical frame numbers, and it labels every entry with the address-space context identifier that was current when the entry was filled. It also holds two model control words. The first is the page-table base word, whose low 12 bits supply the context identifier. The second is the mode word, in which bit 17 turns context tagging on or off.

A lookup is combinational. The requester presents a page number together with a request strobe, and in the same cycle it sees either a hit with the frame number or a miss. On a miss the page walker writes the translation through the fill port, and the new entry can be used from the next cycle.

When a new page-table base is written with tagging off, the whole cache is emptied. With tagging on, the write only switches the current context. Translations that belong to other contexts stay cached and become usable again when their context returns.

Top module: `ctx_tagged_tlb`

## Requirements
- R1: A synchronous reset makes every entry invalid, sets both model words to zero and drives the current context to 0.
- R2: While bit 17 of the stored mode word is 0, the current context is 0. While that bit is 1, the current context equals bits 11:0 of the stored base word. Each model word takes the full value written to it on the clock edge of its write strobe.
- R3: A fill writes into an entry on the clock edge. The entry records the context that was current in the fill cycle. A lookup in that cycle does not yet see the fill. From the next cycle, a lookup of that page number in that context hits, in the same cycle, and returns the filled frame.
- R4: A lookup can hit only on a valid entry whose tag equals the current context. Entries of other contexts are not used, and they still hit once their context is made current again.
- R5: A base-word write while bit 17 of the stored mode word is 0 invalidates every entry. A fill presented in the same cycle is discarded.
- R6: A base-word write while bit 17 of the stored mode word is 1 changes only the current context and keeps every entry.
- R7: A fill whose page number is already present in the current context overwrites that entry in place. It does not consume a replacement slot, so a page number never hits twice.
- R8: Otherwise, a fill takes the lowest-numbered invalid entry. When all entries are valid, it replaces the entry chosen by a round-robin pointer. The pointer starts at entry 0 after reset, advances by one only after such a replacement, and wraps from the last entry back to entry 0.
- R9: With the request strobe high, exactly one of hit and miss is high. With the strobe low, both are low.
- R10: Writing the mode word changes only the enable bit's effect on the current context. It never invalidates entries, whatever the other bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_req | input | 1 | Lookup request strobe |
| lk_vpn | input | 20 | Linear page number to translate |
| lk_hit | output | 1 | Lookup found a translation in the current context |
| lk_miss | output | 1 | Lookup requested and not found |
| lk_pfn | output | 20 | Physical frame of the hitting entry, zero otherwise |
| fill_en | input | 1 | Fill strobe from the page walker |
| fill_vpn | input | 20 | Page number to install |
| fill_pfn | input | 20 | Frame number to install |
| ptb_wr_en | input | 1 | Page-table base word write strobe |
| ptb_wr_data | input | 32 | New base word; bits 11:0 form the context |
| mode_wr_en | input | 1 | Mode word write strobe |
| mode_wr_data | input | 32 | New mode word; bit 17 enables context tagging |
| ptb_q | output | 32 | Stored base word |
| mode_q | output | 32 | Stored mode word |
| cur_ctx | output | 12 | Current context identifier |

## Verification
With tagging off, the bench fills a run of arithmetically spaced page numbers until the cache is full, then keeps filling. The order in which older page numbers begin to miss shows whether free slots are used first, whether the round-robin pointer moves, and whether an overwrite of a cached page number leaves the pointer alone. The bench then sweeps seven context values, each computed from its index, and installs the same page number under every one of them with a different frame. It switches through the contexts again and checks each frame, which separates tag matching from plain page matching, and a context never filled must miss. Base-word writes with tagging off, with tagging on and together with a fill, plus mode-word writes carrying unrelated bits, show the difference between a flush and a pure context switch.

// File: rtl/ctxtlb_pkg.sv
package ctxtlb_pkg;
   // Where a fill lands, in priority order
   typedef enum logic [1:0] {
      SEL_MATCH = 2'd0,   // same page, same context: overwrite
      SEL_FREE  = 2'd1,   // lowest invalid entry
      SEL_ROUND = 2'd2    // round-robin victim
   } fill_src_e;

   localparam int DEF_ENTRIES = 8;
   localparam int DEF_CTX_W   = 12;
   localparam int DEF_VPN_W   = 20;
   localparam int DEF_PFN_W   = 20;
   localparam int DEF_REG_W   = 32;
   localparam int DEF_EN_BIT  = 17;
endpackage

// File: rtl/ctxtlb_ctx_regs.sv
module ctxtlb_ctx_regs #(
   parameter int REG_W  = 32,
   parameter int CTX_W  = 12,
   parameter int EN_BIT = 17
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ptb_wr_en,
   input  logic [REG_W-1:0] ptb_wr_data,
   input  logic             mode_wr_en,
   input  logic [REG_W-1:0] mode_wr_data,
   output logic [REG_W-1:0] ptb_q,
   output logic [REG_W-1:0] mode_q,
   output logic             ctx_en,
   output logic [CTX_W-1:0] cur_ctx,
   output logic             flush_req
);
   if (CTX_W > REG_W) begin : g_bad_ctx
      $error("ctxtlb_ctx_regs: CTX_W wider than REG_W");
   end
   if (EN_BIT >= REG_W) begin : g_bad_en
      $error("ctxtlb_ctx_regs: EN_BIT outside the mode word");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ptb_q  <= '0;
         mode_q <= '0;
      end else begin
         if (ptb_wr_en)  ptb_q  <= ptb_wr_data;
         if (mode_wr_en) mode_q <= mode_wr_data;
      end
   end

   assign ctx_en    = mode_q[EN_BIT];
   assign cur_ctx   = ctx_en ? ptb_q[CTX_W-1:0] : '0;
   // untagged mode: switching tables must drop every cached translation
   assign flush_req = ptb_wr_en && !ctx_en;
endmodule

// File: rtl/ctxtlb_entry_array.sv
module ctxtlb_entry_array #(
   parameter int ENTRIES = 8,
   parameter int CTX_W   = 12,
   parameter int VPN_W   = 20,
   parameter int PFN_W   = 20,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               flush,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [CTX_W-1:0]   cur_ctx,
   input  logic [VPN_W-1:0]   wr_vpn,
   input  logic [PFN_W-1:0]   wr_pfn,
   input  logic [VPN_W-1:0]   lk_vpn,
   output logic [ENTRIES-1:0] valid_vec,
   output logic [ENTRIES-1:0] lk_match,
   output logic [ENTRIES-1:0] fl_match,
   output logic [PFN_W-1:0]   lk_pfn
);
   logic [PFN_W-1:0] pfn_arr [ENTRIES];

   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      logic             v_q;
      logic [CTX_W-1:0] tag_q;
      logic [VPN_W-1:0] vpn_q;
      logic [PFN_W-1:0] pfn_q;
      logic             sel;

      assign sel = wr_en && (wr_idx == IDX_W'(e));

      always_ff @(posedge clk) begin
         if (rst || flush) v_q <= 1'b0;
         else if (sel)     v_q <= 1'b1;
      end

      // payload carries no reset: guarded by v_q
      always_ff @(posedge clk) begin
         if (sel) begin
            tag_q <= cur_ctx;
            vpn_q <= wr_vpn;
            pfn_q <= wr_pfn;
         end
      end

      assign valid_vec[e] = v_q;
      assign lk_match[e]  = v_q && (tag_q == cur_ctx) && (vpn_q == lk_vpn);
      assign fl_match[e]  = v_q && (tag_q == cur_ctx) && (vpn_q == wr_vpn);
      assign pfn_arr[e]   = pfn_q;
   end

   // at most one match by construction of the fill policy: OR-combine
   always_comb begin
      lk_pfn = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (lk_match[i]) lk_pfn = lk_pfn | pfn_arr[i];
      end
   end
endmodule

// File: rtl/ctxtlb_victim_sel.sv
module ctxtlb_victim_sel
   import ctxtlb_pkg::*;
#(
   parameter int ENTRIES = 8,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               fill_fire,
   input  logic [ENTRIES-1:0] valid_vec,
   input  logic [ENTRIES-1:0] fl_match,
   output logic [IDX_W-1:0]   wr_idx
);
   logic [IDX_W-1:0] ptr_q;
   logic [IDX_W-1:0] ptr_nxt;
   logic [IDX_W-1:0] free_idx;
   logic [IDX_W-1:0] hit_idx;
   logic             free_found;
   fill_src_e        src;

   always_comb begin
      free_found = 1'b0;
      free_idx   = '0;
      hit_idx    = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (!valid_vec[i]) begin
            free_found = 1'b1;
            free_idx   = IDX_W'(i);
         end
         if (fl_match[i]) hit_idx = IDX_W'(i);
      end
   end

   always_comb begin
      if (|fl_match) begin
         src    = SEL_MATCH;
         wr_idx = hit_idx;
      end else if (free_found) begin
         src    = SEL_FREE;
         wr_idx = free_idx;
      end else begin
         src    = SEL_ROUND;
         wr_idx = ptr_q;
      end
   end

   if ((ENTRIES & (ENTRIES - 1)) == 0) begin : g_pow2
      assign ptr_nxt = ptr_q + IDX_W'(1);
   end else begin : g_wrap
      assign ptr_nxt = (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + IDX_W'(1);
   end

   always_ff @(posedge clk) begin
      if (rst)                               ptr_q <= '0;
      else if (fill_fire && src == SEL_ROUND) ptr_q <= ptr_nxt;
   end
endmodule

// File: rtl/ctx_tagged_tlb.sv
module ctx_tagged_tlb #(
   parameter int ENTRIES = ctxtlb_pkg::DEF_ENTRIES,
   parameter int CTX_W   = ctxtlb_pkg::DEF_CTX_W,
   parameter int VPN_W   = ctxtlb_pkg::DEF_VPN_W,
   parameter int PFN_W   = ctxtlb_pkg::DEF_PFN_W,
   parameter int REG_W   = ctxtlb_pkg::DEF_REG_W,
   parameter int EN_BIT  = ctxtlb_pkg::DEF_EN_BIT
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             lk_req,
   input  logic [VPN_W-1:0] lk_vpn,
   output logic             lk_hit,
   output logic             lk_miss,
   output logic [PFN_W-1:0] lk_pfn,
   input  logic             fill_en,
   input  logic [VPN_W-1:0] fill_vpn,
   input  logic [PFN_W-1:0] fill_pfn,
   input  logic             ptb_wr_en,
   input  logic [REG_W-1:0] ptb_wr_data,
   input  logic             mode_wr_en,
   input  logic [REG_W-1:0] mode_wr_data,
   output logic [REG_W-1:0] ptb_q,
   output logic [REG_W-1:0] mode_q,
   output logic [CTX_W-1:0] cur_ctx
);
   localparam int IDX_W = $clog2(ENTRIES);

   if (ENTRIES < 2) begin : g_bad_entries
      $error("ctx_tagged_tlb: ENTRIES must be at least 2");
   end
   if (ENTRIES > 64) begin : g_big_entries
      $error("ctx_tagged_tlb: ENTRIES above 64 makes the compare too deep");
   end

   logic               ctx_en;
   logic               flush;
   logic               fill_fire;
   logic [IDX_W-1:0]   wr_idx;
   logic [ENTRIES-1:0] valid_vec;
   logic [ENTRIES-1:0] lk_match;
   logic [ENTRIES-1:0] fl_match;

   ctxtlb_ctx_regs #(
      .REG_W (REG_W),
      .CTX_W (CTX_W),
      .EN_BIT(EN_BIT)
   ) u_regs (
      .clk         (clk),
      .rst         (rst),
      .ptb_wr_en   (ptb_wr_en),
      .ptb_wr_data (ptb_wr_data),
      .mode_wr_en  (mode_wr_en),
      .mode_wr_data(mode_wr_data),
      .ptb_q       (ptb_q),
      .mode_q      (mode_q),
      .ctx_en      (ctx_en),
      .cur_ctx     (cur_ctx),
      .flush_req   (flush)
   );

   // a fill racing a flush belongs to the old table set: drop it
   assign fill_fire = fill_en && !flush;

   ctxtlb_entry_array #(
      .ENTRIES(ENTRIES),
      .CTX_W  (CTX_W),
      .VPN_W  (VPN_W),
      .PFN_W  (PFN_W)
   ) u_array (
      .clk      (clk),
      .rst      (rst),
      .flush    (flush),
      .wr_en    (fill_fire),
      .wr_idx   (wr_idx),
      .cur_ctx  (cur_ctx),
      .wr_vpn   (fill_vpn),
      .wr_pfn   (fill_pfn),
      .lk_vpn   (lk_vpn),
      .valid_vec(valid_vec),
      .lk_match (lk_match),
      .fl_match (fl_match),
      .lk_pfn   (lk_pfn)
   );

   ctxtlb_victim_sel #(
      .ENTRIES(ENTRIES)
   ) u_victim (
      .clk      (clk),
      .rst      (rst),
      .fill_fire(fill_fire),
      .valid_vec(valid_vec),
      .fl_match (fl_match),
      .wr_idx   (wr_idx)
   );

   assign lk_hit  = lk_req && (|lk_match);
   assign lk_miss = lk_req && !(|lk_match);
endmodule

// File: rtl/ctxtlb_checker.sv
module ctxtlb_checker #(
   parameter int ENTRIES = 8,
   parameter int CTX_W   = 12
) (
   input logic               clk,
   input logic               rst,
   input logic               lk_req,
   input logic               lk_hit,
   input logic               lk_miss,
   input logic               fill_en,
   input logic               ptb_wr_en,
   input logic [CTX_W-1:0]   ptb_ctx_in,
   input logic               mode_wr_en,
   input logic               mode_en_in,
   input logic               ctx_en,
   input logic [CTX_W-1:0]   cur_ctx,
   input logic [ENTRIES-1:0] valid_vec,
   input logic [ENTRIES-1:0] lk_match
);
   logic rst_q;
   always_ff @(posedge clk) rst_q <= rst;

   // R1: first cycle after reset is empty and context zero
   p_reset_clean_r1: assert property (@(posedge clk) disable iff (rst)
      rst_q |-> (valid_vec == '0 && cur_ctx == '0));

   // R2: disabling tagging forces context zero
   p_ctx_off_zero_r2: assert property (@(posedge clk) disable iff (rst)
      (mode_wr_en && !mode_en_in) |=> (cur_ctx == '0));

   // R2: a base write under tagging sets the context
   p_ctx_follow_r2: assert property (@(posedge clk) disable iff (rst)
      (ptb_wr_en && ctx_en && !mode_wr_en) |=> (cur_ctx == $past(ptb_ctx_in)));

   // R3: an accepted fill leaves at least one valid entry and loses none
   p_fill_lands_r3: assert property (@(posedge clk) disable iff (rst)
      (fill_en && !(ptb_wr_en && !ctx_en)) |=>
         (valid_vec != '0 && $countones(valid_vec) >= $countones($past(valid_vec))));

   // R5: untagged base write empties the cache
   p_flush_all_r5: assert property (@(posedge clk) disable iff (rst)
      (ptb_wr_en && !ctx_en) |=> (valid_vec == '0));

   // R6: tagged base write keeps every entry
   p_switch_keeps_r6: assert property (@(posedge clk) disable iff (rst)
      (ptb_wr_en && ctx_en && !fill_en) |=> (valid_vec == $past(valid_vec)));

   // R7: never two entries for one page in one context
   p_single_match_r7: assert property (@(posedge clk) disable iff (rst)
      $onehot0(lk_match));

   // R9: hit and miss are exclusive and follow the strobe
   p_hit_miss_r9: assert property (@(posedge clk) disable iff (rst)
      (lk_req |-> (lk_hit != lk_miss)) and (!lk_req |-> (!lk_hit && !lk_miss)));

   // R10: a mode write alone never drops entries
   p_mode_keeps_r10: assert property (@(posedge clk) disable iff (rst)
      (mode_wr_en && !ptb_wr_en && !fill_en) |=> (valid_vec == $past(valid_vec)));
endmodule

bind ctx_tagged_tlb ctxtlb_checker #(
   .ENTRIES(ENTRIES),
   .CTX_W  (CTX_W)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .lk_req    (lk_req),
   .lk_hit    (lk_hit),
   .lk_miss   (lk_miss),
   .fill_en   (fill_en),
   .ptb_wr_en (ptb_wr_en),
   .ptb_ctx_in(ptb_wr_data[CTX_W-1:0]),
   .mode_wr_en(mode_wr_en),
   .mode_en_in(mode_wr_data[EN_BIT]),
   .ctx_en    (ctx_en),
   .cur_ctx   (cur_ctx),
   .valid_vec (valid_vec),
   .lk_match  (lk_match)
);

// File: tb/sim_ctx_tagged_tlb.sv
module sim_ctx_tagged_tlb;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        lk_req = 1'b0;
   logic [19:0] lk_vpn = '0;
   logic        lk_hit, lk_miss;
   logic [19:0] lk_pfn;
   logic        fill_en = 1'b0;
   logic [19:0] fill_vpn = '0, fill_pfn = '0;
   logic        ptb_wr_en = 1'b0;
   logic [31:0] ptb_wr_data = '0;
   logic        mode_wr_en = 1'b0;
   logic [31:0] mode_wr_data = '0;
   logic [31:0] ptb_q, mode_q;
   logic [11:0] cur_ctx;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   ctx_tagged_tlb u0 (
      .clk(clk), .rst(rst), .lk_req(lk_req), .lk_vpn(lk_vpn),
      .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_pfn(lk_pfn),
      .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
      .ptb_wr_en(ptb_wr_en), .ptb_wr_data(ptb_wr_data),
      .mode_wr_en(mode_wr_en), .mode_wr_data(mode_wr_data),
      .ptb_q(ptb_q), .mode_q(mode_q), .cur_ctx(cur_ctx)
   );

   function automatic logic [19:0] vpn_of(input int i);
      return 20'h10000 + 20'(i) * 20'h00111;
   endfunction
   function automatic logic [19:0] pfn_of(input int i);
      return 20'h00100 + 20'(i) * 20'd3;
   endfunction
   function automatic logic [11:0] ctx_of(input int c);
      return 12'(c * 12'h1F1);
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic look(input logic [19:0] vpn, input bit exp_hit, input logic [19:0] exp_pfn, input string req);
      @(negedge clk);
      lk_req = 1'b1;
      lk_vpn = vpn;
      #2;
      chk(lk_hit == exp_hit && lk_miss == !exp_hit, req,
          32'({lk_hit, lk_miss}), 32'({exp_hit, !exp_hit}));
      if (exp_hit) chk(lk_pfn == exp_pfn, req, 32'(lk_pfn), 32'(exp_pfn));
      lk_req = 1'b0;
   endtask

   task automatic fill(input logic [19:0] vpn, input logic [19:0] pfn);
      @(negedge clk);
      fill_en = 1'b1; fill_vpn = vpn; fill_pfn = pfn;
      @(negedge clk);
      fill_en = 1'b0;
   endtask

   task automatic wr_ptb(input logic [31:0] d);
      @(negedge clk);
      ptb_wr_en = 1'b1; ptb_wr_data = d;
      @(negedge clk);
      ptb_wr_en = 1'b0;
   endtask

   task automatic wr_mode(input logic [31:0] d);
      @(negedge clk);
      mode_wr_en = 1'b1; mode_wr_data = d;
      @(negedge clk);
      mode_wr_en = 1'b0;
   endtask

   initial begin
      #(20 * 50000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      #2;
      // R1: reset state
      chk(cur_ctx == 12'h000, "R1 ctx", 32'(cur_ctx), 32'h0);
      chk(ptb_q == 32'h0 && mode_q == 32'h0, "R1 regs", ptb_q | mode_q, 32'h0);
      look(vpn_of(0), 1'b0, '0, "R1 empty");

      // R2: tagging off ignores base bits
      wr_ptb(32'h1234_5ABC);
      #2;
      chk(ptb_q == 32'h1234_5ABC, "R2 ptb store", ptb_q, 32'h1234_5ABC);
      chk(cur_ctx == 12'h000, "R2 off ctx", 32'(cur_ctx), 32'h0);

      // R3: fill timing for entry 0
      @(negedge clk);
      fill_en = 1'b1; fill_vpn = vpn_of(0); fill_pfn = pfn_of(0);
      lk_req = 1'b1; lk_vpn = vpn_of(0);
      #2;
      chk(lk_miss && !lk_hit, "R3 same cycle miss", 32'({lk_hit, lk_miss}), 32'b01);
      @(posedge clk); #2;
      chk(lk_hit && !lk_miss, "R3 next cycle hit", 32'({lk_hit, lk_miss}), 32'b10);
      chk(lk_pfn == pfn_of(0), "R3 pfn", 32'(lk_pfn), 32'(pfn_of(0)));
      @(negedge clk);
      fill_en = 1'b0; lk_req = 1'b0;
      #2;
      // R9: strobe low silences both outputs
      chk(!lk_hit && !lk_miss, "R9 idle", 32'({lk_hit, lk_miss}), 32'b00);

      // R8: remaining free entries then check all
      for (int i = 1; i < 8; i++) fill(vpn_of(i), pfn_of(i));
      for (int i = 0; i < 8; i++) look(vpn_of(i), 1'b1, pfn_of(i), "R3 full hit");
      look(vpn_of(8), 1'b0, '0, "R9 miss");

      // R8: round robin starts at entry 0, then entry 1
      fill(vpn_of(8), pfn_of(8));
      look(vpn_of(0), 1'b0, '0, "R8 victim0");
      look(vpn_of(1), 1'b1, pfn_of(1), "R8 keep1");
      look(vpn_of(8), 1'b1, pfn_of(8), "R8 new8");
      fill(vpn_of(9), pfn_of(9));
      look(vpn_of(1), 1'b0, '0, "R8 victim1");
      look(vpn_of(2), 1'b1, pfn_of(2), "R8 keep2");

      // R7: overwrite in place, pointer unchanged
      fill(vpn_of(2), 20'hABCDE);
      look(vpn_of(2), 1'b1, 20'hABCDE, "R7 overwrite");
      for (int i = 3; i < 10; i++) look(vpn_of(i), 1'b1, pfn_of(i), "R7 no eviction");
      fill(vpn_of(10), pfn_of(10));
      look(vpn_of(2), 1'b0, '0, "R8 victim2");
      look(vpn_of(3), 1'b1, pfn_of(3), "R8 keep3");
      look(vpn_of(10), 1'b1, pfn_of(10), "R8 new10");

      // R5: untagged base write flushes, racing fill dropped
      @(negedge clk);
      ptb_wr_en = 1'b1; ptb_wr_data = 32'h0000_5000;
      fill_en = 1'b1; fill_vpn = 20'h00042; fill_pfn = 20'h00999;
      @(negedge clk);
      ptb_wr_en = 1'b0; fill_en = 1'b0;
      for (int i = 3; i < 11; i++) look(vpn_of(i), 1'b0, '0, "R5 flushed");
      look(20'h00042, 1'b0, '0, "R5 racing fill dropped");

      // R10: enabling tagging keeps an entry
      fill(20'h00042, 20'h00424);
      wr_mode(32'h0002_0000);
      #2;
      chk(mode_q == 32'h0002_0000, "R2 mode store", mode_q, 32'h0002_0000);
      chk(cur_ctx == 12'h000, "R2 on ctx", 32'(cur_ctx), 32'h0);
      look(20'h00042, 1'b1, 20'h00424, "R10 enable keeps");

      // R4/R6: one page, seven contexts
      for (int c = 0; c < 7; c++) begin
         wr_ptb({20'hABCDE, ctx_of(c)});
         #2;
         chk(cur_ctx == ctx_of(c), "R2 ctx follow", 32'(cur_ctx), 32'(ctx_of(c)));
         fill(20'h00777, 20'h00800 + 20'(c));
      end
      for (int c = 6; c >= 0; c--) begin
         wr_ptb({20'h00000, ctx_of(c)});
         look(20'h00777, 1'b1, 20'h00800 + 20'(c), "R6 switch keeps");
         look(20'h00042, c == 0, 20'h00424, "R4 tag filter");
      end
      wr_ptb(32'h0000_0FFF);
      look(20'h00777, 1'b0, '0, "R4 unknown ctx");

      // R10: other mode bits, enable clear
      wr_mode(32'hFFFD_FFFF);
      #2;
      chk(cur_ctx == 12'h000, "R10 ctx zero", 32'(cur_ctx), 32'h0);
      chk(mode_q == 32'hFFFD_FFFF, "R10 mode store", mode_q, 32'hFFFD_FFFF);
      look(20'h00777, 1'b1, 20'h00800, "R10 no flush");
      look(20'h00042, 1'b1, 20'h00424, "R4 ctx0 back");
      wr_mode(32'h0002_0000);
      #2;
      chk(cur_ctx == 12'hFFF, "R2 re-enable", 32'(cur_ctx), 32'hFFF);
      wr_ptb({20'h0, ctx_of(5)});
      look(20'h00777, 1'b1, 20'h00805, "R4 retained");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule